// File: doc/BRIEF.md
# Serial Synthesizer Programming Interface

This block takes configuration words for a dual-loop frequency synthesizer over a three-wire serial link made of a bit clock, a data line and a load strobe. All three lines are oversampled in the system clock domain. Each rising edge of the bit clock moves one data bit into an 18-bit shift register, most significant bit first. When the load strobe rises, the two lowest bits of that register select a destination. The remaining sixteen bits are then split into fields and stored in the selected holding register.

There are two destinations. The reference register holds a 12-bit reference divide value and a 4-bit charge-pump word. The pump word sets pump gain and phase detector polarity. The feedback register holds a 12-bit program count and a 4-bit swallow count. In narrow-band operation the swallow count is limited to three bits, so its top bit is forced to zero. A reference divide value below two raises a sticky range error. The holding register still takes the value, so software can read back what was written.

Top module: `synth_prog_if`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into bit 0 of an 18-bit register and moves every older bit up one place. The first of 18 bits sent therefore ends in bit 17.
- R2: Holding registers change only in response to a rising edge of `ser_load`. The new value appears on the outputs on the third rising `clk` edge after `ser_load` is first seen high. Shifting data without a load strobe leaves every output unchanged.
- R3: Control field value 2'b10 in bits [1:0] selects the reference register. `pump_word` takes bits [17:14] and `ref_div` takes bits [13:2].
- R4: Control field value 2'b01 selects the feedback register. `aux_prog` takes bits [17:6] and `aux_swallow` takes bits [5:2].
- R5: Control field values 2'b00 and 2'b11 update neither holding register.
- R6: A reference load with a divide value of 0 or 1 sets `range_err`, and `ref_div` still takes that value.
- R7: `range_err` stays set through later legal loads and clears only on reset.
- R8: When `band_narrow` is 1 at a feedback load, `aux_swallow` is bits [4:2] with bit 3 forced to 0. When `band_narrow` is 0, all four bits are kept.
- R9: After reset all data outputs are zero and `range_err` is clear.
- R10: If more than 18 bits are shifted before a load, only the last 18 bits count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; its rising edge transfers the word |
| band_narrow | input | 1 | 1 limits the swallow count to three bits |
| pump_word | output | 4 | Charge-pump gain and polarity word |
| ref_div | output | 12 | Reference divide value |
| aux_prog | output | 12 | Feedback program count |
| aux_swallow | output | 4 | Feedback swallow count |
| range_err | output | 1 | Sticky error for an illegal reference divide value |

## Verification
The assertions assume the following about the inputs:
- Every `ser_clk` level lasts several system clocks.
- `ser_dat` is steady across each rising `ser_clk` edge.
- `ser_load` rises only after the last bit clock has fallen.
- `band_narrow` does not change around a load.

Under these conditions the synchronized samples of data and bit clock stay aligned, and the decoded word is stable when the strobe is seen. The stimulus changes data only while the bit clock is low. It holds each level for four system clocks, waits four more before raising the load strobe, and changes `band_narrow` only between complete words.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    localparam int CTL_W          = 2;
    localparam int PUMP_W         = 4;
    localparam int DIV_W          = 12;
    localparam int PROG_W         = 12;
    localparam int SWAL_W         = 4;
    localparam int NARROW_SWAL_W  = 3;
    localparam int SR_W           = CTL_W + PUMP_W + DIV_W;
    localparam int REF_DIV_MIN    = 2;

    localparam logic [CTL_W-1:0] CTL_SEL_REF = 2'b10;
    localparam logic [CTL_W-1:0] CTL_SEL_AUX = 2'b01;

    typedef struct packed {
        logic [PUMP_W-1:0] pump;
        logic [DIV_W-1:0]  div;
    } ref_word_t;

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic [SWAL_W-1:0] swal;
    } aux_word_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pins_in,
    output logic [WIDTH-1:0] pins_out
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = pins_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pins_out = st_q.pipe[STAGES-1];

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter
    import synth_prog_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_lvl,
    input  logic            sdat_lvl,
    output logic [SR_W-1:0] word
);

    typedef struct packed {
        logic [SR_W-1:0] word;
        logic            sclk_prev;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      step;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_lvl;
        step           = sclk_lvl & ~st_q.sclk_prev;
        if (step) begin
            st_d.word = {st_q.word[SR_W-2:0], sdat_lvl};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (word[0] == $past(sdat_lvl)) && (word[SR_W-1:1] == $past(word[SR_W-2:0]))); // R1

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(word)); // R2

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
    import synth_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lvl,
    input  logic              narrow,
    input  logic [SR_W-1:0]   word,
    output logic [PUMP_W-1:0] pump_word,
    output logic [DIV_W-1:0]  ref_div,
    output logic [PROG_W-1:0] aux_prog,
    output logic [SWAL_W-1:0] aux_swallow,
    output logic              range_err
);

    localparam int DIV_LO  = CTL_W;
    localparam int PUMP_LO = CTL_W + DIV_W;
    localparam int SWAL_LO = CTL_W;
    localparam int PROG_LO = CTL_W + SWAL_W;

    typedef struct packed {
        ref_word_t ref_w;
        aux_word_t aux_w;
        logic      err;
        logic      load_prev;
    } latch_st_t;

    latch_st_t         st_d, st_q;
    logic              load;
    logic [CTL_W-1:0]  ctl;
    logic [DIV_W-1:0]  div_in;
    logic [SWAL_W-1:0] swal_in;

    always_comb begin
        st_d           = st_q;
        st_d.load_prev = load_lvl;
        load           = load_lvl & ~st_q.load_prev;
        ctl            = word[CTL_W-1:0];
        div_in         = word[DIV_LO +: DIV_W];
        if (narrow) begin
            swal_in = {{(SWAL_W-NARROW_SWAL_W){1'b0}}, word[SWAL_LO +: NARROW_SWAL_W]};
        end else begin
            swal_in = word[SWAL_LO +: SWAL_W];
        end
        if (load) begin
            case (ctl)
                CTL_SEL_REF: begin
                    st_d.ref_w.pump = word[PUMP_LO +: PUMP_W];
                    st_d.ref_w.div  = div_in;
                    if (div_in < DIV_W'(REF_DIV_MIN)) begin
                        st_d.err = 1'b1;
                    end
                end
                CTL_SEL_AUX: begin
                    st_d.aux_w.prog = word[PROG_LO +: PROG_W];
                    st_d.aux_w.swal = swal_in;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pump_word   = st_q.ref_w.pump;
    assign ref_div     = st_q.ref_w.div;
    assign aux_prog    = st_q.aux_w.prog;
    assign aux_swallow = st_q.aux_w.swal;
    assign range_err   = st_q.err;

    AST_REF_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctl == CTL_SEL_REF) |=> (ref_div == $past(word[DIV_LO +: DIV_W]))
            && (pump_word == $past(word[PUMP_LO +: PUMP_W]))); // R3

    AST_AUX_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctl == CTL_SEL_AUX) |=> (aux_prog == $past(word[PROG_LO +: PROG_W]))); // R4

    AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ref_div) && $stable(pump_word) && $stable(aux_prog) && $stable(aux_swallow)); // R2

    AST_IGNORED_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctl[1] == ctl[0]) |=> $stable(ref_div) && $stable(pump_word)
            && $stable(aux_prog) && $stable(aux_swallow)); // R5

    AST_LOW_DIV_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctl == CTL_SEL_REF && word[DIV_LO +: DIV_W] < DIV_W'(REF_DIV_MIN)) |=> range_err); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |=> range_err); // R7

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ctl == CTL_SEL_AUX && narrow) |=> (aux_swallow[SWAL_W-1] == 1'b0)); // R8

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import synth_prog_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_load,
    input  logic              band_narrow,
    output logic [PUMP_W-1:0] pump_word,
    output logic [DIV_W-1:0]  ref_div,
    output logic [PROG_W-1:0] aux_prog,
    output logic [SWAL_W-1:0] aux_swallow,
    output logic              range_err
);

    localparam int PIN_N = 3;

    logic [PIN_N-1:0] pins_raw;
    logic [PIN_N-1:0] pins_sync;
    logic [SR_W-1:0]  shift_word;

    assign pins_raw = {ser_load, ser_dat, ser_clk};

    pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_raw),
        .pins_out (pins_sync)
    );

    bit_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (pins_sync[0]),
        .sdat_lvl (pins_sync[1]),
        .word     (shift_word)
    );

    cfg_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_lvl    (pins_sync[2]),
        .narrow      (band_narrow),
        .word        (shift_word),
        .pump_word   (pump_word),
        .ref_div     (ref_div),
        .aux_prog    (aux_prog),
        .aux_swallow (aux_swallow),
        .range_err   (range_err)
    );

endmodule

// File: tb/sim_synth_prog_if.sv
module sim_synth_prog_if;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_BIT   = 4;
    localparam int  LATENCY    = 3;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_load = 1'b0;
    logic        band_narrow = 1'b0;
    logic [3:0]  pump_word;
    logic [11:0] ref_div;
    logic [11:0] aux_prog;
    logic [3:0]  aux_swallow;
    logic        range_err;

    int checks = 0;
    int errors = 0;
    string cur_req = "R9";
    bit finished = 0;

    // behavioural model state
    int exp_pump = 0, exp_div = 0, exp_prog = 0, exp_swal = 0, exp_err = 0;
    int pend_cd = 0;
    int pend_word = 0;
    int pend_narrow = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_if u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_dat     (ser_dat),
        .ser_load    (ser_load),
        .band_narrow (band_narrow),
        .pump_word   (pump_word),
        .ref_div     (ref_div),
        .aux_prog    (aux_prog),
        .aux_swallow (aux_swallow),
        .range_err   (range_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Model: apply a load to the expected state
    task automatic model_apply(input int w, input int nar);
        int ctl;
        ctl = w & 3;
        if (ctl == 2) begin
            exp_pump = (w >> 14) & 15;
            exp_div  = (w >> 2) & 4095;
            if (exp_div < 2) exp_err = 1;
        end else if (ctl == 1) begin
            exp_prog = (w >> 6) & 4095;
            if (nar != 0) exp_swal = (w >> 2) & 7;
            else          exp_swal = (w >> 2) & 15;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_pump = 0; exp_div = 0; exp_prog = 0; exp_swal = 0; exp_err = 0;
            pend_cd = 0;
        end else if (pend_cd > 0) begin
            if (pend_cd == 1) model_apply(pend_word, pend_narrow);
            pend_cd--;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            chk(cur_req, "pump_word",   int'(pump_word),   exp_pump);
            chk(cur_req, "ref_div",     int'(ref_div),     exp_div);
            chk(cur_req, "aux_prog",    int'(aux_prog),    exp_prog);
            chk(cur_req, "aux_swallow", int'(aux_swallow), exp_swal);
            chk(cur_req, "range_err",   int'(range_err),   exp_err);
        end
    end

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk);
            ser_dat = v[i];
            repeat (HALF_BIT) @(negedge clk);
            ser_clk = 1'b1;
            repeat (HALF_BIT) @(negedge clk);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe(input int w);
        repeat (HALF_BIT) @(negedge clk);
        ser_load    = 1'b1;
        pend_word   = w;
        pend_narrow = int'(band_narrow);
        pend_cd     = LATENCY;
        repeat (2 * HALF_BIT) @(negedge clk);
        ser_load = 1'b0;
        repeat (HALF_BIT) @(negedge clk);
    endtask

    task automatic load_word(input logic [17:0] w);
        send_bits({14'd0, w}, 18);
        strobe(int'(w));
    endtask

    function automatic logic [17:0] ref_w(input int pump, input int div);
        return {pump[3:0], div[11:0], 2'b10};
    endfunction

    function automatic logic [17:0] aux_w(input int prog, input int swal);
        return {prog[11:0], swal[3:0], 2'b01};
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // R9: reset state
        cur_req = "R9";
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "range_err after reset", int'(range_err), 0);

        // R3: reference word fields
        cur_req = "R3";
        load_word(ref_w(4'hA, 12'h5C3));
        chk("R3", "ref_div", int'(ref_div), 12'h5C3);
        chk("R3", "pump_word", int'(pump_word), 4'hA);

        // R4: feedback word, wide band
        cur_req = "R4";
        load_word(aux_w(12'h9E1, 4'hB));
        chk("R4", "aux_prog", int'(aux_prog), 12'h9E1);
        chk("R4", "aux_swallow", int'(aux_swallow), 4'hB);

        // R8: narrow band masks swallow bit 3
        cur_req = "R8";
        band_narrow = 1'b1;
        load_word(aux_w(12'h123, 4'hD));
        chk("R8", "narrow aux_swallow", int'(aux_swallow), 5);
        band_narrow = 1'b0;
        load_word(aux_w(12'h124, 4'hD));
        chk("R8", "wide aux_swallow", int'(aux_swallow), 13);

        // R1: first bit sent lands in bit 17
        cur_req = "R1";
        load_word(18'h2000A);
        chk("R1", "pump_word msb", int'(pump_word), 8);
        chk("R1", "ref_div", int'(ref_div), 2);

        // R2: shifting without a strobe changes nothing
        cur_req = "R2";
        send_bits({14'd0, ref_w(4'h3, 12'h777)}, 18);
        repeat (20) @(negedge clk);
        chk("R2", "ref_div held", int'(ref_div), 2);

        // R5: ignored control values 00 and 11
        cur_req = "R5";
        load_word({12'hFFF, 4'hF, 2'b00});
        load_word({12'h0F0, 4'h6, 2'b11});
        chk("R5", "ref_div unchanged", int'(ref_div), 2);
        chk("R5", "aux_prog unchanged", int'(aux_prog), 12'h124);

        // R10: extra leading bits fall out
        cur_req = "R10";
        send_bits(32'h1F, 5);
        load_word(aux_w(12'hC35, 4'h2));
        chk("R10", "aux_prog", int'(aux_prog), 12'hC35);
        chk("R10", "aux_swallow", int'(aux_swallow), 2);

        // R6: illegal divide values flag but still store
        cur_req = "R6";
        chk("R6", "range_err before", int'(range_err), 0);
        load_word(ref_w(4'h5, 1));
        chk("R6", "ref_div stored", int'(ref_div), 1);
        chk("R6", "range_err", int'(range_err), 1);
        load_word(ref_w(4'h6, 0));
        chk("R6", "ref_div zero stored", int'(ref_div), 0);

        // R7: sticky through legal loads, cleared by reset
        cur_req = "R7";
        load_word(ref_w(4'h1, 12'hFFF));
        chk("R7", "range_err sticky", int'(range_err), 1);
        chk("R7", "ref_div max", int'(ref_div), 12'hFFF);
        @(negedge clk);
        rst_n = 1'b0;
        cur_req = "R9";
        repeat (3) @(negedge clk);
        chk("R7", "range_err cleared by reset", int'(range_err), 0);
        chk("R9", "aux_prog after reset", int'(aux_prog), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3 again with another pattern after reset
        cur_req = "R3";
        load_word(ref_w(4'h0, 12'h002));
        chk("R3", "min legal ref_div", int'(ref_div), 2);
        chk("R6", "range_err legal min", int'(range_err), 0);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule